// File: doc/BRIEF.md
# Configurable Logic Cell

The block is one programmable cell of a small gate-array style fabric. Two four-input lookup tables (F and G) each compute any function of their own four inputs. A three-input lookup table (H) combines the F and G results with a routed control signal. Two output multiplexers choose what reaches the combinational outputs. Two configurable flip-flops provide registered outputs. Dedicated carry logic turns the F and G tables into a 2-bit adder slice that can be chained through carry ports.

All behaviour is set by a 63-bit configuration word. The word is shifted in serially on the cell clock and takes effect only when a commit strobe arrives. Until the first commit after reset, every output of the cell is held low. Four control pins are routed to four internal roles: H-table input, direct data, set/clear request and clock enable. Any pin can serve any role. Each flip-flop has its own data source, clock edge, set/clear behaviour and global-init value. A global set/reset input forces both flip-flops to their init values.

Top module: `logic_cell`

## Requirements
- R1: While `cfg_en` is high, `cfg_bit` is shifted in on each rising `clk` edge, most significant bit first. A `cfg_done` pulse copies the shifted word into the active configuration. Shifting without `cfg_done` leaves the cell's behaviour unchanged. Field positions in the word are: F table [15:0], G table [31:16], H table [39:32], X select [40], Y select [41], X flop [47:42], Y flop [53:48], H-role pin [55:54], DIN-role pin [57:56], set/clear-role pin [59:58], enable-role pin [61:60], arithmetic mode [62]. Each flop field is {init, falling-edge, mode[1:0], source[1:0]} from high to low.
- R2: After reset, and until the first commit, `x`, `y`, `xq`, `yq` and `carry_out` are all 0.
- R3: Outside arithmetic mode, F' is bit {f_in[3],f_in[2],f_in[1],f_in[0]} of the F table. G' is the same bit of the G table, indexed with `g_in`.
- R4: H' is bit {H-role, G', F'} of the H table.
- R5: `x` carries F' when the X select bit is 0 and H' when it is 1. `y` carries G' when the Y select bit is 0 and H' when it is 1.
- R6: When the enable role is 1, a flip-flop loads its source on its active edge. Source codes are 0 F', 1 G', 2 H', 3 DIN-role. When the enable role is 0, the flip-flop holds its value.
- R7: A flip-flop whose falling-edge bit is 1 loads on the falling `clk` edge. When that bit is 0, it loads on the rising edge.
- R8: While the set/clear role is 1, a flip-flop in mode 1 is forced to 1 and a flip-flop in mode 2 is forced to 0, without waiting for a clock edge. Modes 0 and 3 ignore the role.
- R9: While `gsr` is 1, each flip-flop is forced to its init bit. This overrides R8.
- R10: Each of the four roles takes the value of `c_in[n]`, where n is that role's 2-bit pin field.
- R11: In arithmetic mode, {carry_out, G', F'} = {g_in[1],f_in[1]} + {g_in[0],f_in[0]} + carry_in. Outside arithmetic mode, `carry_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock; also the configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_en | input | 1 | Shift enable for the configuration word |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| cfg_done | input | 1 | Commit strobe for the shifted word |
| gsr | input | 1 | Global set/reset to the flip-flop init values |
| f_in | input | 4 | F table inputs |
| g_in | input | 4 | G table inputs |
| c_in | input | 4 | Control pins routed to the four roles |
| carry_in | input | 1 | Carry from the previous slice |
| x | output | 1 | Combinational output, F' or H' |
| y | output | 1 | Combinational output, G' or H' |
| xq | output | 1 | Registered output of the X flip-flop |
| yq | output | 1 | Registered output of the Y flip-flop |
| carry_out | output | 1 | Carry to the next slice |

## Verification
Two things can act on a flip-flop in the same cycle: the routed set/clear request and the global set/reset. They also compete with the enabled clock load. The bench drives `gsr` together with random control pins whose routing makes the set/clear role active, in configurations where the init bit and the set/clear mode disagree. It judges the registered outputs against a model that applies global init first, then set/clear, then the enabled load. A directed probe shows a falling-edge flop updating half a cycle before a rising-edge one fed by the same data.

// File: rtl/cell_pkg.sv
package cell_pkg;
  localparam int LUT_K     = 4;
  localparam int LUT_W     = 1 << LUT_K;
  localparam int HLUT_K    = 3;
  localparam int HLUT_W    = 1 << HLUT_K;
  localparam int CTL_N     = 4;
  localparam int CTL_SEL_W = $clog2(CTL_N);

  typedef enum logic [1:0] {SRC_F = 2'd0, SRC_G = 2'd1, SRC_H = 2'd2, SRC_DIN = 2'd3} src_e;
  typedef enum logic [1:0] {SRM_OFF = 2'd0, SRM_SET = 2'd1, SRM_CLR = 2'd2, SRM_OFF2 = 2'd3} srm_e;

  typedef struct packed {
    logic init;
    logic fall;
    srm_e mode;
    src_e src;
  } ff_cfg_t;

  typedef struct packed {
    logic [CTL_SEL_W-1:0] ec_pin;
    logic [CTL_SEL_W-1:0] sr_pin;
    logic [CTL_SEL_W-1:0] din_pin;
    logic [CTL_SEL_W-1:0] h1_pin;
  } ctl_map_t;

  typedef struct packed {
    logic              arith;
    ctl_map_t          ctl;
    ff_cfg_t           ff_y;
    ff_cfg_t           ff_x;
    logic              y_sel;
    logic              x_sel;
    logic [HLUT_W-1:0] h_tab;
    logic [LUT_W-1:0]  g_tab;
    logic [LUT_W-1:0]  f_tab;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/cell_cfg_loader.sv
module cell_cfg_loader
  import cell_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_bit,
  input  logic         cfg_done,
  output logic         rst_q,
  output logic [W-1:0] cfg_q,
  output logic         loaded
);
  logic [1:0]   rsync;
  logic [W-1:0] shift_q, shift_d, cfg_d;
  logic         loaded_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q = rsync[1];

  always_comb begin
    shift_d  = shift_q;
    cfg_d    = cfg_q;
    loaded_d = loaded;
    if (cfg_en)   shift_d = {shift_q[W-2:0], cfg_bit};
    if (cfg_done) begin
      cfg_d    = shift_q;
      loaded_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      shift_q <= '0;
      cfg_q   <= '0;
      loaded  <= 1'b0;
    end else begin
      shift_q <= shift_d;
      cfg_q   <= cfg_d;
      loaded  <= loaded_d;
    end
  end

  // R1
  commit_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(loaded) |-> $past(cfg_done));
endmodule

// File: rtl/cell_luts.sv
module cell_luts
  import cell_pkg::*;
#(
  parameter int K  = LUT_K,
  parameter int TW = 1 << K
) (
  input  logic              arith,
  input  logic [K-1:0]      f_in,
  input  logic [K-1:0]      g_in,
  input  logic              h1,
  input  logic              carry_in,
  input  logic [TW-1:0]     f_tab,
  input  logic [TW-1:0]     g_tab,
  input  logic [HLUT_W-1:0] h_tab,
  output logic              f_o,
  output logic              g_o,
  output logic              h_o,
  output logic              carry_out
);
  logic s0, s1, c_mid, c_top;

  always_comb begin
    s0    = f_in[0] ^ f_in[1] ^ carry_in;
    c_mid = (f_in[0] & f_in[1]) | (carry_in & (f_in[0] ^ f_in[1]));
    s1    = g_in[0] ^ g_in[1] ^ c_mid;
    c_top = (g_in[0] & g_in[1]) | (c_mid & (g_in[0] ^ g_in[1]));
    f_o   = arith ? s0 : f_tab[f_in];
    g_o   = arith ? s1 : g_tab[g_in];
    h_o   = h_tab[{h1, g_o, f_o}];
    carry_out = arith & c_top;
  end
endmodule

// File: rtl/cell_ff.sv
module cell_ff
  import cell_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rst_q,
  input  ff_cfg_t cfg,
  input  logic    f_v,
  input  logic    g_v,
  input  logic    h_v,
  input  logic    din,
  input  logic    sr_sig,
  input  logic    ec,
  input  logic    gsr,
  output logic    q
);
  logic clk_eff, gsr_act, set_a, clr_a, d, q_d;

  assign clk_eff = clk ^ cfg.fall;
  assign gsr_act = gsr | ~rst_q;

  always_comb begin
    if (gsr_act) begin
      set_a = cfg.init;
      clr_a = ~cfg.init;
    end else begin
      set_a = sr_sig & (cfg.mode == SRM_SET);
      clr_a = sr_sig & (cfg.mode == SRM_CLR);
    end
    case (cfg.src)
      SRC_F:   d = f_v;
      SRC_G:   d = g_v;
      SRC_H:   d = h_v;
      default: d = din;
    endcase
    q_d = ec ? d : q;
  end

  always_ff @(posedge clk_eff or posedge set_a or posedge clr_a) begin
    if (clr_a)      q <= 1'b0;
    else if (set_a) q <= 1'b1;
    else            q <= q_d;
  end

  // R6
  enabled_load_chk: assert property (@(posedge clk_eff) disable iff (!rst_n || set_a || clr_a)
    ec |=> (q == $past(d)));
  // R6
  disabled_hold_chk: assert property (@(posedge clk_eff) disable iff (!rst_n || set_a || clr_a)
    !ec |=> $stable(q));
  // R8
  async_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_a |-> q) and (clr_a |-> !q));
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import cell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  input  logic             cfg_done,
  input  logic             gsr,
  input  logic [LUT_K-1:0] f_in,
  input  logic [LUT_K-1:0] g_in,
  input  logic [CTL_N-1:0] c_in,
  input  logic             carry_in,
  output logic             x,
  output logic             y,
  output logic             xq,
  output logic             yq,
  output logic             carry_out
);
  localparam int NFF = 2;

  cell_cfg_t  cfg;
  logic       rst_q, loaded;
  logic       h1, din, sr_sig, ec;
  logic       f_v, g_v, h_v, cy;
  ff_cfg_t    ff_cfg [NFF];
  logic [NFF-1:0] q;

  cell_cfg_loader #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .cfg_done(cfg_done), .rst_q(rst_q), .cfg_q(cfg), .loaded(loaded)
  );

  always_comb begin
    h1     = c_in[cfg.ctl.h1_pin];
    din    = c_in[cfg.ctl.din_pin];
    sr_sig = c_in[cfg.ctl.sr_pin];
    ec     = c_in[cfg.ctl.ec_pin];
  end

  cell_luts #(.K(LUT_K)) u_luts (
    .arith(cfg.arith), .f_in(f_in), .g_in(g_in), .h1(h1), .carry_in(carry_in),
    .f_tab(cfg.f_tab), .g_tab(cfg.g_tab), .h_tab(cfg.h_tab),
    .f_o(f_v), .g_o(g_v), .h_o(h_v), .carry_out(cy)
  );

  assign ff_cfg[0] = cfg.ff_x;
  assign ff_cfg[1] = cfg.ff_y;

  for (genvar i = 0; i < NFF; i++) begin : g_ff
    cell_ff u_ff (
      .clk(clk), .rst_n(rst_n), .rst_q(rst_q), .cfg(ff_cfg[i]),
      .f_v(f_v), .g_v(g_v), .h_v(h_v), .din(din),
      .sr_sig(sr_sig), .ec(ec), .gsr(gsr), .q(q[i])
    );
  end

  assign x         = loaded & (cfg.x_sel ? h_v : f_v);
  assign y         = loaded & (cfg.y_sel ? h_v : g_v);
  assign xq        = loaded & q[0];
  assign yq        = loaded & q[1];
  assign carry_out = loaded & cy;

  // R11
  adder_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && cfg.arith) |->
      ({carry_out, g_v, f_v} == 3'({1'b0, g_in[1], f_in[1]} + {1'b0, g_in[0], f_in[0]} + {2'b00, carry_in})));
  // R2
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> ({x, y, xq, yq, carry_out} == 5'b0));
endmodule

// File: tb/sim_logic_cell.sv
`timescale 1ns/1ps
module sim_logic_cell;
  logic clk = 1'b0;
  logic rst_n, cfg_en, cfg_bit, cfg_done, gsr, carry_in;
  logic [3:0] f_in, g_in, c_in;
  logic x, y, xq, yq, carry_out;

  int checks = 0;
  int errors = 0;
  logic [62:0] cur = '0;
  bit loaded_m = 0;
  bit [1:0] qm = '0;
  bit [1:0] vq = '0;

  always #5 clk = ~clk;

  logic_cell u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .cfg_done(cfg_done),
    .gsr(gsr), .f_in(f_in), .g_in(g_in), .c_in(c_in), .carry_in(carry_in),
    .x(x), .y(y), .xq(xq), .yq(yq), .carry_out(carry_out)
  );

  task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void model_comb(input logic [62:0] k, input logic [3:0] f, g, c, input logic cin,
                                     output logic fo, go, ho, xo, yo, co, di, sr, ec);
    logic [2:0] sum;
    logic h1;
    h1 = c[k[55:54]];
    di = c[k[57:56]];
    sr = c[k[59:58]];
    ec = c[k[61:60]];
    sum = {1'b0, g[1], f[1]} + {1'b0, g[0], f[0]} + {2'b00, cin};
    if (k[62]) begin
      fo = sum[0]; go = sum[1]; co = sum[2];
    end else begin
      fo = k[f]; go = k[16 + g]; co = 1'b0;
    end
    ho = k[32 + {h1, go, fo}];
    xo = k[40] ? ho : fo;
    yo = k[41] ? ho : go;
  endfunction

  task automatic load_cfg(input logic [62:0] k, input bit commit);
    @(posedge clk); #1;
    c_in = '0; gsr = 1'b0;
    for (int i = 62; i >= 0; i--) begin
      @(posedge clk); #1;
      cfg_en = 1'b1; cfg_bit = k[i];
    end
    @(posedge clk); #1;
    cfg_en = 1'b0; cfg_done = commit;
    @(posedge clk); #1;
    cfg_done = 1'b0;
    if (commit) begin
      cur = k; loaded_m = 1; vq = '0;
    end
  endtask

  task automatic step(input logic [3:0] f, g, c, input logic cin, input logic gs, input string tag);
    logic fo, go, ho, xo, yo, co, di, sr, ec, d;
    @(posedge clk); #1;
    f_in = f; g_in = g; c_in = c; carry_in = cin; gsr = gs;
    model_comb(cur, f, g, c, cin, fo, go, ho, xo, yo, co, di, sr, ec);
    for (int i = 0; i < 2; i++) begin
      int base;
      base = 42 + 6 * i;
      case (cur[base +: 2])
        2'd0: d = fo;
        2'd1: d = go;
        2'd2: d = ho;
        default: d = di;
      endcase
      if (gs) begin qm[i] = cur[base + 5]; vq[i] = 1; end
      else if (sr && cur[base + 2 +: 2] == 2'd1) begin qm[i] = 1; vq[i] = 1; end
      else if (sr && cur[base + 2 +: 2] == 2'd2) begin qm[i] = 0; vq[i] = 1; end
      else if (ec) begin qm[i] = d; vq[i] = 1; end
    end
    #3;
    if (!loaded_m) begin
      chk("R2", {tag, " comb idle"}, {1'b0, x, y, carry_out}, 4'b0);
    end else begin
      chk("R5", {tag, " x"}, {3'b0, x}, {3'b0, xo});
      chk("R5", {tag, " y"}, {3'b0, y}, {3'b0, yo});
      chk("R11", {tag, " carry_out"}, {3'b0, carry_out}, {3'b0, co});
    end
    @(posedge clk); #2;
    if (!loaded_m) chk("R2", {tag, " regs idle"}, {2'b0, xq, yq}, 4'b0);
    else begin
      if (vq[0]) chk("R6", {tag, " xq"}, {3'b0, xq}, {3'b0, qm[0]});
      if (vq[1]) chk("R6", {tag, " yq"}, {3'b0, yq}, {3'b0, qm[1]});
    end
  endtask

  function automatic logic [62:0] rand_cfg();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [62:0] k;
    void'($urandom(32'd2024));
    rst_n = 0; cfg_en = 0; cfg_bit = 0; cfg_done = 0; gsr = 0;
    f_in = 0; g_in = 0; c_in = 0; carry_in = 0;
    #25 rst_n = 1;
    repeat (3) @(posedge clk);
    #2 chk("R2", "reset outputs", {x, y, xq, carry_out}, 4'b0);
    step(4'hF, 4'hF, 4'hF, 1'b1, 1'b0, "R2 pre-commit");

    // R1 / R3: F table all ones, x=F'; then shift an all-zero table without commit
    k = '0; k[15:0] = 16'hFFFF; k[61:60] = 2'd0;
    load_cfg(k, 1);
    step(4'h5, 4'h0, 4'h1, 1'b0, 1'b0, "R3 all-ones table");
    k[15:0] = 16'h0000;
    load_cfg(k, 0);
    step(4'h5, 4'h0, 4'h1, 1'b0, 1'b0, "R1 no commit");
    chk("R1", "shift without commit", {3'b0, x}, 4'h1);
    load_cfg(k, 1);
    step(4'h5, 4'h0, 4'h1, 1'b0, 1'b0, "R1 committed");
    chk("R1", "after commit", {3'b0, x}, 4'h0);

    // R3 exhaustive index order on a one-hot table
    k = '0; k[15:0] = 16'h0040; k[31:16] = 16'h2000;
    load_cfg(k, 1);
    for (int v = 0; v < 16; v++) begin
      step(4'(v), 4'(v), 4'h0, 1'b0, 1'b0, "R3 sweep");
      chk("R3", "F index", {3'b0, x}, {3'b0, v == 6});
      chk("R3", "G index", {3'b0, y}, {3'b0, v == 13});
    end

    // R10 / R4: H-role from c_in[2], H table passes H-role, x=H'
    k = '0; k[39:32] = 8'hF0; k[40] = 1'b1; k[55:54] = 2'd2; k[61:60] = 2'd3;
    load_cfg(k, 1);
    step(4'h0, 4'h0, 4'b0100, 1'b0, 1'b0, "R10 pin2 high");
    chk("R10", "H-role from pin 2", {3'b0, x}, 4'h1);
    step(4'h0, 4'h0, 4'b1011, 1'b0, 1'b0, "R10 other pins");
    chk("R4", "H ignores other pins", {3'b0, x}, 4'h0);

    // R11 exhaustive adder slice
    k = '0; k[62] = 1'b1;
    load_cfg(k, 1);
    for (int v = 0; v < 32; v++) begin
      logic [2:0] s;
      s = {1'b0, v[3], v[1]} + {1'b0, v[2], v[0]} + {2'b00, v[4]};
      step({2'b0, v[1], v[0]}, {2'b0, v[3], v[2]}, 4'h0, v[4], 1'b0, "R11 sweep");
      chk("R11", "sum and carry", {1'b0, carry_out, y, x}, {1'b0, s});
    end

    // R8 / R9: X set mode init 0, Y clear mode init 1; SR from c_in[1], EC from c_in[0]
    k = '0; k[15:0] = 16'h5555; k[45:44] = 2'd1; k[47] = 1'b0; k[51:50] = 2'd2; k[53] = 1'b1;
    k[59:58] = 2'd1; k[61:60] = 2'd0;
    load_cfg(k, 1);
    step(4'h0, 4'h0, 4'b0001, 1'b0, 1'b0, "R6 load");
    step(4'h0, 4'h0, 4'b0010, 1'b0, 1'b0, "R8 sr active");
    chk("R8", "set mode forces 1 / clear forces 0", {2'b0, xq, yq}, 4'b0010);
    step(4'h0, 4'h0, 4'b0010, 1'b0, 1'b1, "R9 gsr over sr");
    chk("R9", "gsr init wins", {2'b0, xq, yq}, 4'b0001);
    step(4'h1, 4'h0, 4'b0000, 1'b0, 1'b0, "R6 hold");
    chk("R6", "ec low holds", {2'b0, xq, yq}, 4'b0001);

    // R7: X falling edge, Y rising edge, both sourced from F' = f_in[0]
    k = '0; k[15:0] = 16'hAAAA; k[46] = 1'b1; k[61:60] = 2'd0;
    load_cfg(k, 1);
    step(4'h0, 4'h0, 4'b0001, 1'b0, 1'b0, "R7 prime");
    @(posedge clk); #1 f_in = 4'h1;
    @(negedge clk); #2;
    chk("R7", "falling flop updated, rising not yet", {2'b0, xq, yq}, 4'b0010);
    @(posedge clk); #2;
    chk("R7", "both updated after rising edge", {2'b0, xq, yq}, 4'b0011);
    qm = 2'b11;

    // Random mix
    for (int n = 0; n < 30; n++) begin
      load_cfg(rand_cfg(), 1);
      for (int s = 0; s < 20; s++) begin
        step(4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom),
             ($urandom % 8) == 0, "random");
      end
    end

    // R2 after a fresh reset
    @(posedge clk); #1 rst_n = 0;
    #20 rst_n = 1; loaded_m = 0;
    repeat (3) @(posedge clk);
    #2 chk("R2", "outputs after reset", {x, y, xq, yq}, 4'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule